// File: doc/BRIEF.md
# Capacitor sort-and-select balancer

The balancer decides, once per control step, which submodules of one converter arm are switched into the current path. On a start pulse it captures the capacitor voltage of every submodule as an unsigned word, together with a signed insertion request, a topology select and the sign of the arm current. It then ranks the submodules against each other and, when ranking is complete, publishes an insert mask and a polarity mask with a single-cycle done strobe.

The request sign and the current sign together decide whether the inserted cells will charge or discharge. A charging arm takes the cells with the least stored voltage and a discharging arm takes the cells with the most, which pulls the capacitor voltages together over many steps. In full-bridge mode a negative request inserts cells with reversed polarity. In half-bridge mode only non-negative requests are legal. Requests that cannot be met are clamped and flagged.

Ranking uses one comparator column per submodule. It sweeps a single reference cell per clock, so a result takes N+1 clock edges after the start edge. The published masks stay unchanged until the next result.

Top module: `sort_select_balancer`

## Requirements
- R1: On each done strobe the insert mask has exactly min(|s|, N) bits set, where s is the captured request (two's complement on count_i), except in the half-bridge case of R6.
- R2: When charging, the inserted cells are those with the lowest captured voltages.
- R3: When discharging, the inserted cells are those with the highest captured voltages.
- R4: The arm is charging when s > 0 with cur_pos_i = 1, or when s < 0 with cur_pos_i = 0. Otherwise it is discharging. cur_pos_i = 1 means positive arm current.
- R5: Equal voltages are ordered by index, and the lower index is preferred in both directions.
- R6: In half-bridge mode (fb_mode_i = 0) a negative s inserts nothing and raises err_o. In this mode neg_o is always all zero.
- R7: In full-bridge mode (fb_mode_i = 1) with s < 0, every inserted cell has its neg_o bit set to 1, where 1 means negative polarity. With s > 0, every neg_o bit is 0.
- R8: A cell that is not inserted has insert_o = 0 and neg_o = 0, which is the bypass state. A request of s = 0 bypasses every cell.
- R9: If |s| > N, the count is clamped to N and err_o is high for exactly the one cycle in which done_o is high. For legal requests err_o stays low.
- R10: done_o is high for one cycle, N+1 rising edges after the edge that accepted start_i.
- R11: Between done strobes the outputs hold their values. A start_i that arrives while a ranking is in progress is ignored.
- R12: After reset, insert_o, neg_o, done_o and err_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture inputs and begin ranking (taken only when idle) |
| vcap_i | input | N_SM*VW | Capacitor voltages; cell i at bits [i*VW +: VW] |
| count_i | input | $clog2(N_SM+1)+2 | Signed requested insertion count s |
| fb_mode_i | input | 1 | 1 = full-bridge cells, 0 = half-bridge cells |
| cur_pos_i | input | 1 | 1 = arm current positive |
| insert_o | output | N_SM | Per-cell insert mask |
| neg_o | output | N_SM | Per-cell polarity, 1 = inserted negatively |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Request out of range, pulsed with done_o |

## Verification
The bench targets voltage ties, which a comparator with the wrong strictness or tie order would resolve to the higher index or to too many cells. It also drives each of the four combinations of request sign and current sign, because an error in the sign product would swap lowest and highest. The out-of-range cases (s of N+1, a large negative value in full-bridge mode, and a negative value in half-bridge mode) would expose a missing clamp or a stuck or absent err_o. A second start while ranking is in progress, and input changes after done, would catch a design that restarts mid-ranking or lets its outputs follow the live inputs.

// File: rtl/bal_pkg.sv
package bal_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RANK, ST_EMIT} bal_state_e;

  typedef struct packed {
    logic neg;
    logic charge;
    logic err;
  } bal_req_t;
endpackage

// File: rtl/bal_req_decode.sv
module bal_req_decode import bal_pkg::*; #(
  parameter int N_SM = 8,
  parameter int CW   = 6,
  parameter int MW   = 4
) (
  input  logic signed [CW-1:0] count_i,
  input  logic                 fb_i,
  input  logic                 cur_pos_i,
  output logic [MW-1:0]        mag_o,
  output bal_req_t             req_o
);
  logic          neg_req;
  logic          over;
  logic [CW-1:0] abs_v;

  assign neg_req = count_i[CW-1];
  assign abs_v   = neg_req ? CW'(-count_i) : CW'(count_i);
  assign over    = abs_v > CW'(N_SM);

  always_comb begin
    req_o.neg    = fb_i & neg_req;
    req_o.charge = (count_i != '0) & (neg_req ^ cur_pos_i);
    if (!fb_i && neg_req) begin
      mag_o     = '0;
      req_o.err = 1'b1;
    end else if (over) begin
      mag_o     = MW'(N_SM);
      req_o.err = 1'b1;
    end else begin
      mag_o     = abs_v[MW-1:0];
      req_o.err = 1'b0;
    end
  end
endmodule

// File: rtl/bal_ctrl.sv
module bal_ctrl import bal_pkg::*; #(
  parameter int N_SM = 8,
  parameter int IW   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          cap_o,
  output logic          step_o,
  output logic          emit_o,
  output logic [IW-1:0] idx_o
);
  bal_state_e    st_q;
  logic [IW-1:0] idx_q;

  assign cap_o  = (st_q == ST_IDLE) && start_i;
  assign step_o = (st_q == ST_RANK);
  assign emit_o = (st_q == ST_EMIT);
  assign idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_RANK;
          idx_q <= '0;
        end
        ST_RANK: begin
          idx_q <= idx_q + IW'(1);
          if (idx_q == IW'(N_SM - 1)) st_q <= ST_EMIT;
        end
        ST_EMIT: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bal_rank_cell.sv
module bal_rank_cell #(
  parameter int VW   = 12,
  parameter int IW   = 3,
  parameter int RW   = 4,
  parameter int SELF = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic          charge_i,
  input  logic [VW-1:0] v_self_i,
  input  logic [VW-1:0] v_ref_i,
  input  logic [IW-1:0] idx_i,
  output logic [RW-1:0] rank_o
);
  logic beat;
  logic tie_win;

  // reference cell ranks ahead: better voltage, or equal with lower index
  assign tie_win = (v_ref_i == v_self_i) && (idx_i < IW'(SELF));
  assign beat    = charge_i ? ((v_ref_i < v_self_i) || tie_win)
                            : ((v_ref_i > v_self_i) || tie_win);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rank_o <= '0;
    else if (clr_i)          rank_o <= '0;
    else if (step_i && beat) rank_o <= rank_o + RW'(1);
  end
endmodule

// File: rtl/sort_select_balancer.sv
module sort_select_balancer import bal_pkg::*; #(
  parameter  int N_SM = 8,
  parameter  int VW   = 12,
  localparam int CW   = $clog2(N_SM + 1) + 2,
  localparam int IW   = $clog2(N_SM),
  localparam int RW   = $clog2(N_SM + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [N_SM*VW-1:0]   vcap_i,
  input  logic signed [CW-1:0] count_i,
  input  logic                 fb_mode_i,
  input  logic                 cur_pos_i,
  output logic [N_SM-1:0]      insert_o,
  output logic [N_SM-1:0]      neg_o,
  output logic                 done_o,
  output logic                 err_o
);
  logic          cap, step, emit;
  logic [IW-1:0] idx;
  logic [RW-1:0] mag_d, mag_q;
  bal_req_t      req_d, req_q;
  logic [VW-1:0] vq   [N_SM];
  logic [RW-1:0] rank [N_SM];
  logic [VW-1:0] v_ref;

  bal_req_decode #(.N_SM(N_SM), .CW(CW), .MW(RW)) u_dec (
    .count_i  (count_i),
    .fb_i     (fb_mode_i),
    .cur_pos_i(cur_pos_i),
    .mag_o    (mag_d),
    .req_o    (req_d)
  );

  bal_ctrl #(.N_SM(N_SM), .IW(IW)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .cap_o  (cap),
    .step_o (step),
    .emit_o (emit),
    .idx_o  (idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_q <= '0;
      req_q <= '0;
      for (int i = 0; i < N_SM; i++) vq[i] <= '0;
    end else if (cap) begin
      mag_q <= mag_d;
      req_q <= req_d;
      for (int i = 0; i < N_SM; i++) vq[i] <= vcap_i[i*VW +: VW];
    end
  end

  assign v_ref = vq[idx];

  for (genvar g = 0; g < N_SM; g++) begin : g_cell
    bal_rank_cell #(.VW(VW), .IW(IW), .RW(RW), .SELF(g)) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (cap),
      .step_i  (step),
      .charge_i(req_q.charge),
      .v_self_i(vq[g]),
      .v_ref_i (v_ref),
      .idx_i   (idx),
      .rank_o  (rank[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      insert_o <= '0;
      neg_o    <= '0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      done_o <= emit;
      err_o  <= emit & req_q.err;
      if (emit) begin
        for (int i = 0; i < N_SM; i++) begin
          insert_o[i] <= rank[i] < mag_q;
          neg_o[i]    <= (rank[i] < mag_q) & req_q.neg;
        end
      end
    end
  end
endmodule

// File: rtl/sort_select_balancer_chk.sv
module sort_select_balancer_chk #(
  parameter int N_SM = 8,
  parameter int RW   = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_SM-1:0] insert_o,
  input logic [N_SM-1:0] neg_o,
  input logic            done_o,
  input logic            err_o,
  input logic [RW-1:0]   mag_q,
  input logic            neg_q
);
  p_count_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones(insert_o) == int'(mag_q));

  p_pos_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !neg_q) |-> neg_o == '0);

  p_fb_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && neg_q) |-> neg_o == insert_o);

  p_bypass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (neg_o & ~insert_o) == '0);

  p_err_with_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(insert_o) && $stable(neg_o)));
endmodule

bind sort_select_balancer sort_select_balancer_chk #(.N_SM(N_SM), .RW(RW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .insert_o(insert_o),
  .neg_o   (neg_o),
  .done_o  (done_o),
  .err_o   (err_o),
  .mag_q   (mag_q),
  .neg_q   (req_q.neg)
);

// File: tb/sort_select_balancer_tb.sv
module sort_select_balancer_tb;
  localparam int N  = 8;
  localparam int VW = 12;
  localparam int CW = $clog2(N + 1) + 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [N*VW-1:0]   vcap;
  logic signed [CW-1:0] count = '0;
  logic              fb = 1'b0;
  logic              cur = 1'b0;
  logic [N-1:0]      insert_o, neg_o;
  logic              done_o, err_o;

  int v [N];
  int s = 0;
  int errors = 0;
  int checks = 0;
  string tag = "R12";

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) vcap[i*VW +: VW] = v[i][VW-1:0];
  end

  sort_select_balancer #(.N_SM(N), .VW(VW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vcap_i(vcap),
    .count_i(count), .fb_mode_i(fb), .cur_pos_i(cur),
    .insert_o(insert_o), .neg_o(neg_o), .done_o(done_o), .err_o(err_o));

  task automatic chk(input string t, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h at %0t", t, got, exp, $time);
    end
  endtask

  task automatic ref_calc(output logic [N-1:0] ins, output logic [N-1:0] ng, output logic er);
    int a, mag, best;
    bit chg;
    ins = '0; ng = '0; er = 1'b0;
    if (!fb && s < 0) begin
      mag = 0; er = 1'b1;
    end else begin
      a = (s < 0) ? -s : s;
      if (a > N) begin mag = N; er = 1'b1; end
      else mag = a;
    end
    chg = (s > 0 && cur) || (s < 0 && !cur);
    for (int k = 0; k < mag; k++) begin
      best = -1;
      for (int i = 0; i < N; i++)
        if (!ins[i])
          if (best < 0 || (chg ? (v[i] < v[best]) : (v[i] > v[best]))) best = i;
      ins[best] = 1'b1;
      ng[best]  = (s < 0);
    end
  endtask

  // reference model, stepped on every rising edge
  int rem = 0;
  logic [N-1:0] p_ins = '0, p_neg = '0, e_ins = '0, e_neg = '0;
  logic p_err = 1'b0, e_err = 1'b0, e_done = 1'b0;

  always @(posedge clk) begin
    if (rst_n) begin
      e_done = 1'b0;
      e_err  = 1'b0;
      if (rem == 0) begin
        if (start) begin
          ref_calc(p_ins, p_neg, p_err);
          rem = N + 1;
        end
      end else begin
        rem--;
        if (rem == 0) begin
          e_ins = p_ins; e_neg = p_neg; e_err = p_err; e_done = 1'b1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk({tag, " done"},   {31'd0, done_o}, {31'd0, e_done});
      chk({tag, " err"},    {31'd0, err_o},  {31'd0, e_err});
      chk({tag, " insert"}, 32'(insert_o),   32'(e_ins));
      chk({tag, " neg"},    32'(neg_o),      32'(e_neg));
    end
  end

  task automatic set_v(input int a0, a1, a2, a3, a4, a5, a6, a7);
    v[0] = a0; v[1] = a1; v[2] = a2; v[3] = a3;
    v[4] = a4; v[5] = a5; v[6] = a6; v[7] = a7;
  endtask

  task automatic run(input string t, input int req, input bit f, input bit c,
                     input logic [N-1:0] x_ins, input logic [N-1:0] x_neg, input bit x_err);
    int cyc;
    tag = t;
    s = req; fb = f; cur = c; count = CW'(req);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    chk({t, " latency R10"}, 32'(cyc - 1), 32'(N + 1));
    chk({t, " mask"}, 32'(insert_o), 32'(x_ins));
    chk({t, " polarity"}, 32'(neg_o), 32'(x_neg));
    chk({t, " error"}, {31'd0, err_o}, {31'd0, x_err});
    @(negedge clk);
    chk({t, " done pulse R10"}, {31'd0, done_o}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] ri, rn;
    logic re;
    set_v(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R12 reset insert", 32'(insert_o), 32'd0);
    chk("R12 reset neg", 32'(neg_o), 32'd0);
    chk("R12 reset done", {31'd0, done_o}, 32'd0);
    chk("R12 reset err", {31'd0, err_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    set_v(500, 300, 700, 100, 900, 200, 800, 400);
    run("R2 hb charge low",      3, 1'b0, 1'b1, 8'b0010_1010, 8'h00, 1'b0);
    run("R3 hb discharge high",  3, 1'b0, 1'b0, 8'b0101_0100, 8'h00, 1'b0);
    run("R4 fb neg charge",     -2, 1'b1, 1'b0, 8'b0010_1000, 8'b0010_1000, 1'b0);
    run("R7 fb neg discharge",  -2, 1'b1, 1'b1, 8'b0101_0000, 8'b0101_0000, 1'b0);
    run("R4 fb pos discharge",   2, 1'b1, 1'b0, 8'b0101_0000, 8'h00, 1'b0);
    run("R8 zero request",       0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0);
    run("R1 fb full",            8, 1'b1, 1'b1, 8'hFF, 8'h00, 1'b0);
    run("R9 hb over",            9, 1'b0, 1'b1, 8'hFF, 8'h00, 1'b1);
    run("R9 fb neg over",      -20, 1'b1, 1'b0, 8'hFF, 8'hFF, 1'b1);
    run("R6 hb negative",       -3, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1);

    set_v(600, 600, 600, 600, 600, 600, 600, 600);
    run("R5 tie charge",         3, 1'b0, 1'b1, 8'b0000_0111, 8'h00, 1'b0);
    run("R5 tie discharge",      3, 1'b0, 1'b0, 8'b0000_0111, 8'h00, 1'b0);
    set_v(900, 100, 500, 100, 900, 500, 100, 900);
    run("R5 partial tie low",    2, 1'b0, 1'b1, 8'b0000_1010, 8'h00, 1'b0);
    run("R5 partial tie high",   2, 1'b0, 1'b0, 8'b0001_0001, 8'h00, 1'b0);

    // R11: second start while ranking, then input changes without start
    tag = "R11 busy start";
    set_v(500, 300, 700, 100, 900, 200, 800, 400);
    s = 3; fb = 1'b0; cur = 1'b1; count = CW'(3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    set_v(1, 2, 3, 4, 5, 6, 7, 8);
    s = 5; cur = 1'b0; count = CW'(5);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    chk("R11 busy start ignored", 32'(insert_o), 32'(8'b0010_1010));
    tag = "R11 hold";
    set_v(9, 9, 9, 9, 9, 9, 9, 9);
    s = -4; fb = 1'b1; count = CW'(-4);
    repeat (15) @(negedge clk);
    chk("R11 hold mask", 32'(insert_o), 32'(8'b0010_1010));
    chk("R11 hold neg", 32'(neg_o), 32'd0);

    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < N; i++)
        v[i] = (n % 3 == 0) ? int'($urandom_range(3)) * 100 : int'($urandom_range(4095));
      s   = int'($urandom_range(20)) - 10;
      fb  = 1'($urandom_range(1));
      cur = 1'($urandom_range(1));
      ref_calc(ri, rn, re);
      run("R1 random", s, fb, cur, ri, rn, re);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule